// File: doc/BRIEF.md
# Charge Current Soft-Start Ramp Generator

This block sits between the programmed charge-current setting and the current regulation loop. It produces the current reference code that is actually applied. When charging is switched on, the reference does not jump to the programmed value. It begins at a fixed non-zero floor and climbs toward the programmed target in fixed increments, holding each level for a fixed number of clock cycles. This keeps the output capacitors and the power stage free of overshoot.

A mode input selects the increment and the hold time. In continuous conduction, the defaults are one code step (64 mA per code on a 10 mΩ sense resistor) held for 400 µs. In discontinuous conduction, the loop responds more slowly, so the increment is larger and the hold is longer; the defaults are 128 mA and 800 µs. All inputs and the output are plain level signals, so there is no handshake or back-pressure. A target of zero, or a target above the legal maximum, counts as "do not charge". Dropping the enable clears the reference on the next clock. The next enable restarts the ramp from the floor.

Top module: `soft_start_ramp`

## Requirements
- R1: After reset, and while `chg_en` is low, `iref_code` is 0.
- R2: On the first clock edge that sees `chg_en` high with a valid target at or above `START_CODE`, `iref_code` becomes `START_CODE`.
- R3: If a valid target is below `START_CODE`, `iref_code` goes directly to the target on the first enabled edge and stays there.
- R4: With `dcm_mode`=0 (continuous conduction), each level is held for `CONT_DWELL` cycles, then rises by `CONT_STEP`.
- R5: With `dcm_mode`=1 (discontinuous conduction), each level is held for `DISC_DWELL` cycles, then rises by `DISC_STEP`.
- R6: The ramp never passes the target. A step that would overshoot lands exactly on the target, and the output then holds there.
- R7: When `chg_en` is deasserted, `iref_code` is 0 after the next edge. A later enable restarts the ramp from `START_CODE`.
- R8: A target of 0 or above `MAX_CODE` with `chg_en` high gives `iref_code` 0 after the next edge, the same as a disable.
- R9: A target lowered below the current output during a ramp is applied on the next edge.
- R10: A target raised after the ramp has settled resumes stepping. The first new step comes on the dwell-th edge that sees the raised target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chg_en | input | 1 | Charge enable; a rising level starts a new ramp |
| target_code | input | CODE_W | Programmed charge-current target code |
| dcm_mode | input | 1 | Conduction mode: 0 continuous, 1 discontinuous |
| iref_code | output | CODE_W | Applied charge-current reference code |

## Verification
A scoreboard compares every cycle against values worked out from the ramp rule. The bench uses a tall continuous ramp that never reaches its target, and a discontinuous ramp that overshoots and clamps; together these separate step size, dwell and clamping. A target below the floor shows that no floor is forced. Targets of zero and of one above the maximum show the validity check. A mid-ramp reduction followed by an increase separates the two update paths: the immediate drop, and stepping that resumes with a fresh dwell.

// File: rtl/ss_ramp_pkg.sv
package ss_ramp_pkg;
  typedef enum logic {
    COND_CONT = 1'b0,
    COND_DISC = 1'b1
  } cond_mode_e;
endpackage

// File: rtl/ss_dwell_timer.sv
module ss_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  always_comb tick = run && (cnt_q >= (limit - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4
  dwell_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));

  // R5
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/ss_step_add.sv
module ss_step_add #(
  parameter int CODE_W = 7
) (
  input  logic [CODE_W-1:0] level,
  input  logic [CODE_W-1:0] step,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] next_level
);
  logic [CODE_W:0] sum;

  always_comb begin
    sum = {1'b0, level} + {1'b0, step};
    if (sum >= {1'b0, target}) next_level = target;
    else                       next_level = sum[CODE_W-1:0];
  end
endmodule

// File: rtl/soft_start_ramp.sv
module soft_start_ramp
  import ss_ramp_pkg::*;
#(
  parameter int CODE_W     = 7,
  parameter int MAX_CODE   = 100,
  parameter int START_CODE = 2,
  parameter int CONT_STEP  = 1,
  parameter int DISC_STEP  = 2,
  parameter int CONT_DWELL = 40000,
  parameter int DISC_DWELL = 80000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chg_en,
  input  logic [CODE_W-1:0] target_code,
  input  logic              dcm_mode,
  output logic [CODE_W-1:0] iref_code
);
  localparam int LONG_DWELL = (CONT_DWELL > DISC_DWELL) ? CONT_DWELL : DISC_DWELL;
  localparam int BIG_STEP   = (CONT_STEP > DISC_STEP) ? CONT_STEP : DISC_STEP;
  localparam int CNT_W      = $clog2(LONG_DWELL + 1);
  localparam logic [CODE_W-1:0] START_C = CODE_W'(START_CODE);
  localparam logic [CODE_W-1:0] MAX_C   = CODE_W'(MAX_CODE);

  cond_mode_e        mode;
  logic              tgt_ok;
  logic              run_q;
  logic [CODE_W-1:0] iref_q;
  logic [CODE_W-1:0] step_sel;
  logic [CNT_W-1:0]  dwell_sel;
  logic [CODE_W-1:0] stepped;
  logic              climbing;
  logic              tick;

  always_comb begin
    mode      = cond_mode_e'(dcm_mode);
    tgt_ok    = chg_en && (target_code != '0) && (target_code <= MAX_C);
    climbing  = run_q && tgt_ok && (iref_q < target_code);
    step_sel  = (mode == COND_DISC) ? CODE_W'(DISC_STEP)  : CODE_W'(CONT_STEP);
    dwell_sel = (mode == COND_DISC) ? CNT_W'(DISC_DWELL) : CNT_W'(CONT_DWELL);
  end

  ss_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (climbing),
    .limit (dwell_sel),
    .tick  (tick)
  );

  ss_step_add #(.CODE_W(CODE_W)) u_step (
    .level      (iref_q),
    .step       (step_sel),
    .target     (target_code),
    .next_level (stepped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      iref_q <= '0;
    end else if (!tgt_ok) begin
      run_q  <= 1'b0;
      iref_q <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      iref_q <= (target_code < START_C) ? target_code : START_C;
    end else if (target_code < iref_q) begin
      iref_q <= target_code;
    end else if (tick) begin
      iref_q <= stepped;
    end
  end

  assign iref_code = iref_q;

  // R7
  chg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_en |=> (iref_code == '0));

  // R8
  bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && ((target_code == '0) || (target_code > MAX_C))) |=> (iref_code == '0));

  // R2
  start_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (iref_code <= START_C));

  // R6
  no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $stable(target_code)) |-> (iref_code <= target_code));

  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> (!run_q || ({1'b0, iref_code} <= {1'b0, $past(iref_code)} + (CODE_W+1)'(BIG_STEP))));
endmodule

// File: tb/tb_soft_start_ramp.sv
module tb_soft_start_ramp;
  localparam int W     = 7;
  localparam int MAXC  = 100;
  localparam int START = 2;
  localparam int CSTEP = 1;
  localparam int DSTEP = 2;
  localparam int CDW   = 4;
  localparam int DDW   = 6;

  typedef struct {
    int    val;
    string req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chg_en = 1'b0;
  logic [W-1:0] target_code = '0;
  logic         dcm_mode = 1'b0;
  logic [W-1:0] iref_code;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  soft_start_ramp #(
    .CODE_W(W), .MAX_CODE(MAXC), .START_CODE(START),
    .CONT_STEP(CSTEP), .DISC_STEP(DSTEP),
    .CONT_DWELL(CDW), .DISC_DWELL(DDW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en),
    .target_code(target_code), .dcm_mode(dcm_mode), .iref_code(iref_code)
  );

  // Monitor: one expected item per cycle, sampled after the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (int'(iref_code) != e.val) begin
        n_bad++;
        $display("FAIL %s: iref_code got %0d expected %0d", e.req, iref_code, e.val);
      end
    end
  end

  task automatic drive(input bit en, input int tgt, input bit dcm, input int ev, input string req);
    exp_t e;
    @(negedge clk);
    chg_en      = en;
    target_code = W'(tgt);
    dcm_mode    = dcm;
    e.val = ev;
    e.req = req;
    q.push_back(e);
  endtask

  function automatic int ramp_val(int tgt, bit dcm, int k);
    int v;
    if (tgt < START) return tgt;
    v = START + (dcm ? DSTEP : CSTEP) * (k / (dcm ? DDW : CDW));
    return (v > tgt) ? tgt : v;
  endfunction

  task automatic ramp(input int tgt, input bit dcm, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      int ev;
      ev = ramp_val(tgt, dcm, k);
      drive(1'b1, tgt, dcm, ev, (k == 0) ? "R2" : ((ev == tgt) ? "R6" : req));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    for (int i = 0; i < 3; i++) drive(1'b0, 0, 1'b0, 0, "R1");
    // R4: continuous ramp that does not reach its target
    ramp(20, 1'b0, 24, "R4");
    // R7: disable clears on the next edge
    for (int i = 0; i < 2; i++) drive(1'b0, 20, 1'b0, 0, "R7");
    // R5: discontinuous ramp that clamps at an odd target
    ramp(11, 1'b1, 34, "R5");
    drive(1'b0, 11, 1'b1, 0, "R7");
    // R7: restart from floor, run to completion (R6)
    ramp(9, 1'b0, 40, "R7");
    drive(1'b0, 9, 1'b0, 0, "R7");
    // R3: target under the floor
    ramp(1, 1'b0, 5, "R3");
    // R8: zero and out-of-range targets
    for (int i = 0; i < 3; i++) drive(1'b1, 0, 1'b0, 0, "R8");
    for (int i = 0; i < 3; i++) drive(1'b1, MAXC + 1, 1'b0, 0, "R8");
    // R9: lower mid-ramp (output 6 at that point)
    ramp(20, 1'b0, 17, "R4");
    for (int i = 0; i < 4; i++) drive(1'b1, 4, 1'b0, 4, "R9");
    // R10: raise after settling
    for (int k = 0; k < 12; k++) begin
      int ev;
      ev = 4 + (k + 1) / CDW;
      drive(1'b1, 8, 1'b0, (ev > 8) ? 8 : ev, "R10");
    end
    drive(1'b0, 8, 1'b0, 0, "R7");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule